// File: doc/BRIEF.md
# PCM Serial Transmit Port

This block takes the 8-bit companded sample from an encoder and puts it on a serial PCM highway, most significant (sign) bit first. All external timing inputs are oversampled by a faster system clock. Each one passes through a two-flop synchronizer, and the block acts on the rising and falling edges it detects. A static strap picks one of two timing schemes.

In fixed-rate timing, a rising frame sync arms the port. The following eight rising edges of the master clock shift the word out. An active-low slot strobe frames the slot so that it can enable an external tri-state buffer. In variable-rate timing, the same input becomes a slot enable, and a separate data clock shifts the bits. While the enable stays high, the port sends the same word again in every later slot. The serial output's high-impedance state is shown by an explicit output-enable pin. A new sample is taken in only at the start of a slot, so the word sent is always the sample captured before that slot began.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, and until the first slot starts, `sdata_oe` is 0, `slot_n` is 1 and `sdata` is 0.
- R2: With `mode_var`=0 (fixed-rate), the word goes out MSB (bit 7, sign) first, one bit per rising edge of `mclk`, on the first eight such edges after `fsync` rises.
- R3: In fixed-rate timing, `slot_n` goes low on the `mclk` rising edge that launches bit 1. It returns high on the `mclk` falling edge that ends bit 8. `sdata_oe` follows the same window.
- R4: In fixed-rate timing, once the `mclk` falling edge of bit 8 has passed, `sdata_oe` stays 0 until the next rise of `fsync`, even if `fsync` is held high and `mclk` keeps running.
- R5: With `mode_var`=1 (variable-rate), while `fsync` is high the word goes out MSB first on the next eight rising edges of `dclk`. `sdata_oe` drops on the `dclk` falling edge that ends bit 8, and `slot_n` stays 1 throughout.
- R6: In variable-rate timing, while `fsync` stays high, each later group of eight `dclk` rising edges sends the same word again. This holds even if `word_vld` has delivered a new sample in the meantime.
- R7: A word presented with `word_vld`=1 is held and sent in the next slot that starts. A word that arrives while a slot is in progress does not change that slot.
- R8: In variable-rate timing, `fsync` going low ends the slot at once (`sdata_oe` falls within the synchronizer delay). The next enable window starts with the latest held sample.
- R9: Whenever `sdata_oe` is 0, `sdata` is 0.
- R10: The inactive bit clock has no effect: `mclk` edges do nothing in variable-rate timing, and `dclk` edges do nothing in fixed-rate timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than every external clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_var | input | 1 | Timing strap: 0 fixed-rate, 1 variable-rate |
| word_in | input | 8 | Parallel sample from the encoder |
| word_vld | input | 1 | One-cycle strobe that captures `word_in` |
| mclk | input | 1 | Master clock; the bit clock in fixed-rate timing |
| fsync | input | 1 | Frame sync (fixed-rate) or slot enable (variable-rate) |
| dclk | input | 1 | Data clock used in variable-rate timing |
| sdata | output | 1 | Serial PCM data, valid while `sdata_oe` is 1 |
| sdata_oe | output | 1 | Serial output enable; 0 stands for high impedance |
| slot_n | output | 1 | Active-low slot strobe (fixed-rate only) |

## Verification
The shift path is tried with words of differing bit patterns in both timings: alternating bits, a lone MSB, a lone LSB, and the all-ones and all-zeros words. These separate a reversed bit order, an off-by-one bit count and a stuck output. Back-to-back variable-rate slots with a new sample delivered between them show whether a repeat slot reuses the held word. An enable that is dropped and raised again shows that the latest sample is then taken. Samples written in the middle of a slot, extra clock edges after bit 8, an enable dropped partway through a slot, and edges on the unused bit clock each check that the port ignores input it must not act on.

// File: rtl/pcm_tx_pkg.sv
// Shared types for the PCM serial transmit port.
package pcm_tx_pkg;

    // Timing scheme picked by the strap input.
    typedef enum logic {
        TIMING_FIXED = 1'b0,
        TIMING_VAR   = 1'b1
    } timing_e;

    // Result of synchronizing one external timing input.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_ev_t;

endpackage

// File: rtl/pcm_edge_sync.sv
// Synchronizes one asynchronous input into clk and reports its level and
// single-cycle rise/fall pulses. Assumes the input holds each level for
// at least two clk periods.
module pcm_edge_sync
    import pcm_tx_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     async_in,
    output edge_ev_t ev_o
);
    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    // Shift the input through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[TOP-1:0], async_in};
            prev_q  <= chain_q[TOP];
        end
    end

    // Decode level and edges.
    always_comb begin
        ev_o.level = chain_q[TOP];
        ev_o.rise  = chain_q[TOP] & ~prev_q;
        ev_o.fall  = ~chain_q[TOP] & prev_q;
    end
endmodule

// File: rtl/pcm_word_latch.sv
// Holds the most recent encoder sample until a slot picks it up.
// Assumes word_vld is a one-cycle strobe in the clk domain.
module pcm_word_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] held_o
);
    // Capture a new sample on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_o <= '0;
        else if (load_i)
            held_o <= data_i;
    end
endmodule

// File: rtl/pcm_tx_seq.sv
// Slot sequencer and shift register. In fixed timing, a frame-sync rise arms
// one slot clocked by mclk. In variable timing, the enable level gates slots
// clocked by dclk and repeats the current word while the enable stays high.
// Assumes edges arrive as single-cycle pulses from pcm_edge_sync.
module pcm_tx_seq
    import pcm_tx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  timing_e      mode_i,
    input  edge_ev_t     mclk_i,
    input  edge_ev_t     dclk_i,
    input  edge_ev_t     fs_i,
    input  logic [W-1:0] pend_i,
    output logic         sdata_o,
    output logic         oe_o,
    output logic         slot_n_o
);
    localparam int unsigned     CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     shreg_q;
    logic [W-1:0]     cur_q;
    logic [CNT_W-1:0] cnt_q;
    logic             oe_q;
    logic             strobe_n_q;
    logic             armed_q;
    logic             run_q;
    logic [W-1:0]     start_word;
    logic             at_last;

    // A repeat slot reuses the current word; a fresh window takes the held sample.
    always_comb begin
        start_word = run_q ? cur_q : pend_i;
        at_last    = (cnt_q == LAST);
    end

    // Slot control and bit shifting for both timing schemes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            cur_q      <= '0;
            cnt_q      <= '0;
            oe_q       <= 1'b0;
            strobe_n_q <= 1'b1;
            armed_q    <= 1'b0;
            run_q      <= 1'b0;
        end else if (mode_i == TIMING_FIXED) begin
            run_q <= 1'b0;
            if (mclk_i.rise && armed_q) begin
                shreg_q    <= pend_i;
                cur_q      <= pend_i;
                cnt_q      <= '0;
                oe_q       <= 1'b1;
                strobe_n_q <= 1'b0;
                armed_q    <= 1'b0;
            end else if (mclk_i.rise && oe_q && !at_last) begin
                shreg_q <= {shreg_q[W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end else if (mclk_i.fall && oe_q && at_last) begin
                oe_q       <= 1'b0;
                strobe_n_q <= 1'b1;
            end
            if (fs_i.rise)
                armed_q <= 1'b1;
        end else begin
            armed_q    <= 1'b0;
            strobe_n_q <= 1'b1;
            if (!fs_i.level) begin
                oe_q  <= 1'b0;
                run_q <= 1'b0;
                cnt_q <= '0;
            end else if (dclk_i.rise && !oe_q) begin
                shreg_q <= start_word;
                cur_q   <= start_word;
                cnt_q   <= '0;
                oe_q    <= 1'b1;
                run_q   <= 1'b1;
            end else if (dclk_i.rise && oe_q && !at_last) begin
                shreg_q <= {shreg_q[W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end else if (dclk_i.fall && oe_q && at_last) begin
                oe_q <= 1'b0;
            end
        end
    end

    // Drive outputs; data is parked low while disabled.
    always_comb begin
        sdata_o  = oe_q & shreg_q[W-1];
        oe_o     = oe_q;
        slot_n_o = strobe_n_q;
    end
endmodule

// File: rtl/pcm_tx_port.sv
// PCM serial transmit port: synchronizes the external timing inputs, holds
// the encoder sample and shifts it out in fixed or variable timing.
// Assumes clk runs at least four times faster than any external clock and
// that mode_var only changes while no slot is active.
module pcm_tx_port
    import pcm_tx_pkg::*;
#(
    parameter int unsigned PCM_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_var,
    input  logic [PCM_W-1:0] word_in,
    input  logic             word_vld,
    input  logic             mclk,
    input  logic             fsync,
    input  logic             dclk,
    output logic             sdata,
    output logic             sdata_oe,
    output logic             slot_n
);
    localparam int unsigned N_SYNC = 3;
    localparam int unsigned IX_MCLK = 0;
    localparam int unsigned IX_FS   = 1;
    localparam int unsigned IX_DCLK = 2;

    logic [N_SYNC-1:0] raw_in;
    edge_ev_t          ev [N_SYNC];
    logic [PCM_W-1:0]  pend_word;

    // Gather the external timing inputs for the synchronizer bank.
    always_comb begin
        raw_in          = '0;
        raw_in[IX_MCLK] = mclk;
        raw_in[IX_FS]   = fsync;
        raw_in[IX_DCLK] = dclk;
    end

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[g]),
            .ev_o     (ev[g])
        );
    end

    pcm_word_latch #(.W(PCM_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (word_vld),
        .data_i (word_in),
        .held_o (pend_word)
    );

    pcm_tx_seq #(.W(PCM_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (timing_e'(mode_var)),
        .mclk_i   (ev[IX_MCLK]),
        .dclk_i   (ev[IX_DCLK]),
        .fs_i     (ev[IX_FS]),
        .pend_i   (pend_word),
        .sdata_o  (sdata),
        .oe_o     (sdata_oe),
        .slot_n_o (slot_n)
    );
endmodule

// File: rtl/pcm_tx_chk.sv
// Port-level properties of pcm_tx_port, attached by bind.
module pcm_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_var,
    input logic sdata,
    input logic sdata_oe,
    input logic slot_n
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sdata_oe && slot_n && !sdata));

    // R3
    strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_var |-> (slot_n == !sdata_oe));

    // R5
    var_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_var |-> slot_n);

    // R9
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata);
endmodule

bind pcm_tx_port pcm_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_var (mode_var),
    .sdata    (sdata),
    .sdata_oe (sdata_oe),
    .slot_n   (slot_n)
);

// File: tb/sim_pcm_tx_port.sv
module sim_pcm_tx_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;
    localparam int NVEC = 6;
    // {mode_var, word}
    localparam logic [8:0] VEC [NVEC] = '{
        9'h0A5, 9'h080, 9'h001, 9'h13C, 9'h1FF, 9'h100
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_var = 1'b0;
    logic [7:0] word_in = '0;
    logic word_vld = 1'b0;
    logic mclk = 1'b0;
    logic fsync = 1'b0;
    logic dclk = 1'b0;
    logic sdata, sdata_oe, slot_n;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_tx_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_var(mode_var), .word_in(word_in),
        .word_vld(word_vld), .mclk(mclk), .fsync(fsync), .dclk(dclk),
        .sdata(sdata), .sdata_oe(sdata_oe), .slot_n(slot_n)
    );

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [7:0] w);
        word_in = w; word_vld = 1'b1;
        wait_sys(1);
        word_vld = 1'b0;
        wait_sys(1);
    endtask

    task automatic edge_rise(input bit on_d);
        if (on_d) dclk = 1'b1; else mclk = 1'b1;
        wait_sys(HALF);
    endtask

    task automatic edge_fall(input bit on_d);
        if (on_d) dclk = 1'b0; else mclk = 1'b0;
        wait_sys(HALF);
    endtask

    // One full slot; optionally delivers a new sample mid-slot.
    task automatic run_slot(input bit on_d, input logic [7:0] exp, input string req,
                            input bit mid_en, input logic [7:0] mid_w);
        logic [7:0] got = '0;
        for (int i = 0; i < 8; i++) begin
            edge_rise(on_d);
            got = {got[6:0], sdata};
            if (i == 0) check({7'b0, sdata_oe}, 8'd1, "R2/R5 oe up");
            if (!on_d && (i == 0 || i == 7)) check({7'b0, slot_n}, 8'd0, "R3 strobe low");
            if (on_d && i == 0) check({7'b0, slot_n}, 8'd1, "R5 strobe idle");
            if (mid_en && i == 3) load_word(mid_w);
            edge_fall(on_d);
        end
        check(got, exp, req);
        check({7'b0, sdata_oe}, 8'd0, "R4/R5 oe down after bit 8");
        check({7'b0, slot_n}, 8'd1, "R3 strobe high after bit 8");
        check({7'b0, sdata}, 8'd0, "R9 parked low");
    endtask

    initial begin
        wait_sys(3);
        // R1 reset state
        check({5'b0, sdata_oe, slot_n, sdata}, 8'b010, "R1 in reset");
        rst_n = 1'b1;
        wait_sys(4);
        check({5'b0, sdata_oe, slot_n, sdata}, 8'b010, "R1 after reset");

        // Vector table: main function, both timings (R2, R5)
        for (int v = 0; v < NVEC; v++) begin
            mode_var = VEC[v][8];
            load_word(VEC[v][7:0]);
            fsync = 1'b1;
            wait_sys(HALF);
            run_slot(mode_var, VEC[v][7:0], mode_var ? "R5 word" : "R2 word", 1'b0, 8'h00);
            fsync = 1'b0;
            wait_sys(HALF);
        end

        // R6 repeat keeps word; R7/R8 new window takes latest sample
        mode_var = 1'b1;
        load_word(8'h5A);
        fsync = 1'b1; wait_sys(HALF);
        run_slot(1'b1, 8'h5A, "R6 first slot", 1'b0, 8'h00);
        load_word(8'hC3);
        run_slot(1'b1, 8'h5A, "R6 repeat slot", 1'b0, 8'h00);
        fsync = 1'b0; wait_sys(HALF);
        fsync = 1'b1; wait_sys(HALF);
        run_slot(1'b1, 8'hC3, "R8 new window", 1'b0, 8'h00);

        // R8 enable dropped mid-slot
        for (int i = 0; i < 3; i++) begin edge_rise(1'b1); edge_fall(1'b1); end
        check({7'b0, sdata_oe}, 8'd1, "R8 mid-slot oe");
        fsync = 1'b0; wait_sys(HALF);
        check({7'b0, sdata_oe}, 8'd0, "R8 oe off on enable low");

        // R10 mclk ignored in variable timing
        fsync = 1'b1; wait_sys(HALF);
        edge_rise(1'b0);
        check({7'b0, sdata_oe}, 8'd0, "R10 mclk in var mode");
        edge_fall(1'b0);
        fsync = 1'b0; wait_sys(HALF);

        // R7 fixed timing: mid-slot sample waits
        mode_var = 1'b0;
        load_word(8'h11);
        fsync = 1'b1; wait_sys(HALF);
        run_slot(1'b0, 8'h11, "R7 mid-slot write", 1'b1, 8'h22);
        // R4 no repeat while sync stays high
        edge_rise(1'b0);
        check({7'b0, sdata_oe}, 8'd0, "R4 extra mclk edge");
        check({7'b0, slot_n}, 8'd1, "R4 strobe stays high");
        edge_fall(1'b0);
        fsync = 1'b0; wait_sys(HALF);
        fsync = 1'b1; wait_sys(HALF);
        run_slot(1'b0, 8'h22, "R7 next frame", 1'b0, 8'h00);
        fsync = 1'b0; wait_sys(HALF);

        // R10 dclk ignored in fixed timing
        edge_rise(1'b1);
        check({7'b0, sdata_oe}, 8'd0, "R10 dclk in fixed mode");
        edge_fall(1'b1);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule